// File: doc/BRIEF.md
# Length-Coded Inter-Core Data Transponder

This block is a shared mailbox cell. One writer at a time loads a value into it, and any number of cores read it at the same time. The writer sends its value over a four-bit serial link. Each transfer starts with a two-clock header that carries a size code. The size comes from the value itself: if bits 31..16 hold anything nonzero the transfer is a long, otherwise if bits 15..8 hold anything nonzero it is a word, otherwise it is a byte. So a byte crosses the link in fewer clocks than a word, and a word in fewer than a long.

The cell keeps the last complete value. It sends that value out on a four-bit return link again and again, with each message directly after the previous one, and nothing has to ask for it. Each reader picks a size mode, waits for the next message start, and assembles the low nibbles of that message. The reader then reports the result together with a carry flag and a zero flag. A value that lands while a message is in flight is held back until the next message start, so no message ever mixes two values.

Top module: `xpdr_mailbox`

## Requirements
- R1: A write request accepted while the writer is idle raises `wr_busy` for exactly 4 cycles when bits 31..8 of the value are zero, for 6 cycles when only bits 31..16 are zero, and for 10 cycles otherwise.
- R2: A write request that arrives while `wr_busy` is high is ignored, and the value held by the cell does not change.
- R3: The return link carries messages back to back, with no request needed. `bc_sop` is high on the first of two header cycles. Both header nibbles hold the size code: 0 for byte, 1 for word, 2 for long. The data follows as 2, 4 or 8 nibbles, least significant first. After reset the cell broadcasts the byte value 0.
- R4: A completed write takes effect at the first message start after the cell holds it. If the write completes on the very clock edge that starts a message, that message still carries the old value and the next message carries the new one. No message ever mixes two values.
- R5: The reader mode selects a byte (0), a word (1) or a long (2 or 3). The reader takes the smaller of the mode's nibble count and the message's nibble count, and returns those nibbles with all higher bits zero.
- R6: The reader's carry output equals bit 7, 15 or 31 of the result, matching the reader's mode.
- R7: The reader's zero output is high exactly when the returned result is zero.
- R8: Let N be the number of nibbles the reader takes and L the length of the current message. `rd_done` pulses for one cycle, at the edge between 1+N and L+N edges after the edge that sampled the request.
- R9: Readers are independent. Two readers asked in the same cycle with different modes each return their own correct result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_req | input | 1 | Write request, sampled when the writer is idle |
| wr_data | input | 32 | Value to store |
| wr_busy | output | 1 | Writer is shifting a transfer onto the link |
| rd_req | input | N_RD | Read request, one bit per reader |
| rd_mode | input | 2*N_RD | Size mode, two bits per reader |
| rd_done | output | N_RD | One-cycle result strobe per reader |
| rd_data | output | 32*N_RD | Result per reader, with higher bits zero-filled |
| rd_c | output | N_RD | MSB of each reader's result at its mode width |
| rd_z | output | N_RD | High when each reader's result is zero |
| bc_sop | output | 1 | Start of a broadcast message |
| bc_nib | output | 4 | Broadcast link nibble |

## Verification
Two events can fall on the same clock edge: a write finishing in the cell, and the broadcaster starting a new message. The bench provokes this by watching `bc_sop`. From it the bench computes the next message boundary, and it places a write request so that the last nibble arrives exactly on that edge, and in a second run one clock earlier. It decodes every broadcast message, tagged with its start cycle. It then judges that the coincident case defers the new value by one message, while the early case shows it at once. A second overlap is a read request sampled on the same edge as a message start; latency bounds at both ends cover it.

// File: rtl/xpdr_pkg.sv
// Shared constants, size type and size helpers for the mailbox transponder.
// Assumes byte/word/long granularity over a 32-bit value carried as nibbles.
package xpdr_pkg;
    localparam int DATA_W   = 32;
    localparam int NIB_W    = 4;
    localparam int HDR_LEN  = 2;
    localparam int MAX_NIBS = DATA_W / NIB_W;
    localparam int CNT_W    = $clog2(HDR_LEN + MAX_NIBS);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2
    } xsize_e;

    // Size class chosen by the highest nonzero region of a value
    function automatic xsize_e size_of(input logic [DATA_W-1:0] d);
        if (d[DATA_W-1:16] != '0)
            return SZ_LONG;
        else if (d[15:8] != '0)
            return SZ_WORD;
        else
            return SZ_BYTE;
    endfunction

    // Decode a two-bit code (header or reader mode); code 3 means long
    function automatic xsize_e code_size(input logic [1:0] c);
        case (c)
            2'd0:    return SZ_BYTE;
            2'd1:    return SZ_WORD;
            default: return SZ_LONG;
        endcase
    endfunction

    // Data nibbles carried for a size class
    function automatic logic [CNT_W-1:0] nibs_of(input xsize_e s);
        case (s)
            SZ_BYTE: return CNT_W'(2);
            SZ_WORD: return CNT_W'(4);
            default: return CNT_W'(MAX_NIBS);
        endcase
    endfunction

    // Index of the final cycle of a link transfer of the given size
    function automatic logic [CNT_W-1:0] last_of(input xsize_e s);
        return CNT_W'(HDR_LEN - 1) + nibs_of(s);
    endfunction
endpackage

// File: rtl/xpdr_wr_ser.sv
// Writer-side serializer. Takes one value while idle, sends a two-cycle header
// with the size code, then the data nibbles, least significant first.
// Assumes a single writer; requests while busy are dropped.
module xpdr_wr_ser
    import xpdr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [DATA_W-1:0] data,
    output logic              busy,
    output logic              lnk_sop,
    output logic [NIB_W-1:0]  lnk_nib
);
    logic              act;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  last;
    logic [DATA_W-1:0] shreg;
    xsize_e            sz;

    // Accept, count and shift one transfer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act   <= 1'b0;
            cnt   <= '0;
            last  <= '0;
            shreg <= '0;
            sz    <= SZ_BYTE;
        end else if (!act) begin
            if (req) begin
                act   <= 1'b1;
                cnt   <= '0;
                sz    <= size_of(data);
                last  <= last_of(size_of(data));
                shreg <= data;
            end
        end else if (cnt == last) begin
            act <= 1'b0;
        end else begin
            cnt <= cnt + 1'b1;
            if (cnt >= CNT_W'(HDR_LEN))
                shreg <= shreg >> NIB_W;
        end
    end

    // Drive header code or current data nibble
    always_comb begin
        busy    = act;
        lnk_sop = act && (cnt == '0);
        if (cnt < CNT_W'(HDR_LEN))
            lnk_nib = {{(NIB_W-2){1'b0}}, sz};
        else
            lnk_nib = shreg[NIB_W-1:0];
    end

    // R2
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act && req && cnt != last) |=> (act && $stable(sz) && $stable(last)));
endmodule

// File: rtl/xpdr_cell_rx.sv
// Cell receive side. Rebuilds a value from the writer link and parks it as
// pending until the broadcaster takes it at a message boundary. A newer
// value simply replaces a pending one. Assumes headers only start when idle.
module xpdr_cell_rx
    import xpdr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sop,
    input  logic [NIB_W-1:0]  nib,
    input  logic              take,
    output logic              pend_vld,
    output logic [DATA_W-1:0] pend_val,
    output xsize_e            pend_sz
);
    logic              rx_on;
    logic [CNT_W-1:0]  rcnt;
    logic [CNT_W-1:0]  rlast;
    xsize_e            rsz;
    logic [DATA_W-1:0] acc;
    logic [DATA_W-1:0] acc_nx;
    logic [CNT_W-1:0]  didx;
    logic              rx_end;

    // Merge the incoming nibble into the partial value
    always_comb begin
        didx   = rcnt - CNT_W'(HDR_LEN);
        acc_nx = acc | (DATA_W'(nib) << (didx * NIB_W));
        rx_end = rx_on && (rcnt == rlast);
    end

    // Track transfer progress and the pending slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_on    <= 1'b0;
            rcnt     <= '0;
            rlast    <= '0;
            rsz      <= SZ_BYTE;
            acc      <= '0;
            pend_vld <= 1'b0;
            pend_val <= '0;
            pend_sz  <= SZ_BYTE;
        end else begin
            if (take)
                pend_vld <= 1'b0;
            if (!rx_on) begin
                if (sop) begin
                    rx_on <= 1'b1;
                    rcnt  <= CNT_W'(1);
                    rsz   <= code_size(nib[1:0]);
                    rlast <= last_of(code_size(nib[1:0]));
                    acc   <= '0;
                end
            end else begin
                if (rcnt >= CNT_W'(HDR_LEN))
                    acc <= acc_nx;
                if (rx_end) begin
                    rx_on    <= 1'b0;
                    pend_vld <= 1'b1;
                    pend_val <= acc_nx;
                    pend_sz  <= rsz;
                end else begin
                    rcnt <= rcnt + 1'b1;
                end
            end
        end
    end

    // R4
    take_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !rx_end) |=> !pend_vld);
endmodule

// File: rtl/xpdr_bcast.sv
// Looping broadcaster. Holds the current value and sends it as back-to-back
// messages. The held value only changes on the edge that starts a new
// message, so a message is never mixed. Assumes pending data is valid while
// pend_vld is high.
module xpdr_bcast
    import xpdr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pend_vld,
    input  logic [DATA_W-1:0] pend_val,
    input  xsize_e            pend_sz,
    output logic              take,
    output logic              sop,
    output logic [NIB_W-1:0]  nib
);
    logic [DATA_W-1:0] held_val;
    xsize_e            held_sz;
    logic [CNT_W-1:0]  bcnt;
    logic [CNT_W-1:0]  blast;
    logic [CNT_W-1:0]  didx;
    logic [DATA_W-1:0] shv;

    // Message length and outgoing nibble selection
    always_comb begin
        blast = last_of(held_sz);
        take  = (bcnt == blast) && pend_vld;
        didx  = bcnt - CNT_W'(HDR_LEN);
        shv   = held_val >> (didx * NIB_W);
        sop   = (bcnt == '0);
        if (bcnt < CNT_W'(HDR_LEN))
            nib = {{(NIB_W-2){1'b0}}, held_sz};
        else
            nib = shv[NIB_W-1:0];
    end

    // Advance through the message; reload held value at the wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_val <= '0;
            held_sz  <= SZ_BYTE;
            bcnt     <= '0;
        end else if (bcnt == blast) begin
            bcnt <= '0;
            if (pend_vld) begin
                held_val <= pend_val;
                held_sz  <= pend_sz;
            end
        end else begin
            bcnt <= bcnt + 1'b1;
        end
    end

    // R4
    no_tear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bcnt != '0) |-> ($stable(held_val) && $stable(held_sz)));

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bcnt <= last_of(held_sz));
endmodule

// File: rtl/xpdr_rd_des.sv
// Reader-side deserializer. Arms on a request, waits for a message start,
// skips the header and gathers as many nibbles as both its mode and the
// message allow. Returns a zero-filled result with carry and zero flags.
// Assumes requests while a read is in progress are dropped.
module xpdr_rd_des
    import xpdr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [1:0]        mode,
    input  logic              sop,
    input  logic [NIB_W-1:0]  nib,
    output logic              done,
    output logic [DATA_W-1:0] data,
    output logic              carry,
    output logic              zero
);
    typedef enum logic [1:0] {R_IDLE, R_WAIT, R_HDR, R_DAT} rstate_e;

    rstate_e           st;
    xsize_e            mode_q;
    xsize_e            mode_eff;
    xsize_e            hsz;
    logic [CNT_W-1:0]  need;
    logic [CNT_W-1:0]  need_nx;
    logic [CNT_W-1:0]  dcnt;
    logic [DATA_W-1:0] acc;
    logic [DATA_W-1:0] acc_nx;
    logic [5:0]        msb_idx;

    // Next-need, nibble merge and flag bit position
    always_comb begin
        mode_eff = (st == R_IDLE) ? code_size(mode) : mode_q;
        hsz      = code_size(nib[1:0]);
        need_nx  = (nibs_of(mode_eff) < nibs_of(hsz)) ? nibs_of(mode_eff) : nibs_of(hsz);
        acc_nx   = acc | (DATA_W'(nib) << (dcnt * NIB_W));
        msb_idx  = 6'(nibs_of(mode_q) * NIB_W - 1);
    end

    // Read sequencer and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= R_IDLE;
            mode_q <= SZ_BYTE;
            need   <= '0;
            dcnt   <= '0;
            acc    <= '0;
            done   <= 1'b0;
            data   <= '0;
            carry  <= 1'b0;
            zero   <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                R_IDLE: begin
                    if (req) begin
                        mode_q <= code_size(mode);
                        if (sop) begin
                            st   <= R_HDR;
                            need <= need_nx;
                        end else begin
                            st <= R_WAIT;
                        end
                    end
                end
                R_WAIT: begin
                    if (sop) begin
                        st   <= R_HDR;
                        need <= need_nx;
                    end
                end
                R_HDR: begin
                    st   <= R_DAT;
                    dcnt <= '0;
                    acc  <= '0;
                end
                default: begin
                    if (dcnt == need - 1'b1) begin
                        st    <= R_IDLE;
                        done  <= 1'b1;
                        data  <= acc_nx;
                        carry <= acc_nx[msb_idx];
                        zero  <= (acc_nx == '0);
                    end else begin
                        dcnt <= dcnt + 1'b1;
                        acc  <= acc_nx;
                    end
                end
            endcase
        end
    end

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5
    byte_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mode_q == SZ_BYTE) |-> (data[DATA_W-1:8] == '0));
endmodule

// File: rtl/xpdr_mailbox.sv
// Top of the transponder: writer serializer, cell receive side, looping
// broadcaster and one deserializer per reader. Assumes one writer source.
module xpdr_mailbox
    import xpdr_pkg::*;
#(
    parameter int N_RD = 2
)(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_req,
    input  logic [DATA_W-1:0]      wr_data,
    output logic                   wr_busy,
    input  logic [N_RD-1:0]        rd_req,
    input  logic [2*N_RD-1:0]      rd_mode,
    output logic [N_RD-1:0]        rd_done,
    output logic [DATA_W*N_RD-1:0] rd_data,
    output logic [N_RD-1:0]        rd_c,
    output logic [N_RD-1:0]        rd_z,
    output logic                   bc_sop,
    output logic [NIB_W-1:0]       bc_nib
);
    logic              w_sop;
    logic [NIB_W-1:0]  w_nib;
    logic              take;
    logic              pend_vld;
    logic [DATA_W-1:0] pend_val;
    xsize_e            pend_sz;

    xpdr_wr_ser u_wr (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (wr_req),
        .data    (wr_data),
        .busy    (wr_busy),
        .lnk_sop (w_sop),
        .lnk_nib (w_nib)
    );

    xpdr_cell_rx u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .sop      (w_sop),
        .nib      (w_nib),
        .take     (take),
        .pend_vld (pend_vld),
        .pend_val (pend_val),
        .pend_sz  (pend_sz)
    );

    xpdr_bcast u_bc (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend_vld (pend_vld),
        .pend_val (pend_val),
        .pend_sz  (pend_sz),
        .take     (take),
        .sop      (bc_sop),
        .nib      (bc_nib)
    );

    for (genvar gi = 0; gi < N_RD; gi++) begin : g_rd
        xpdr_rd_des u_rd (
            .clk   (clk),
            .rst_n (rst_n),
            .req   (rd_req[gi]),
            .mode  (rd_mode[2*gi +: 2]),
            .sop   (bc_sop),
            .nib   (bc_nib),
            .done  (rd_done[gi]),
            .data  (rd_data[DATA_W*gi +: DATA_W]),
            .carry (rd_c[gi]),
            .zero  (rd_z[gi])
        );
    end
endmodule

// File: tb/sim_xpdr_mailbox.sv
module sim_xpdr_mailbox;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_req = 1'b0;
    logic [31:0] wr_data = '0;
    logic        wr_busy;
    logic [1:0]  rd_req = '0;
    logic [3:0]  rd_mode = '0;
    logic [1:0]  rd_done;
    logic [63:0] rd_data;
    logic [1:0]  rd_c;
    logic [1:0]  rd_z;
    logic        bc_sop;
    logic [3:0]  bc_nib;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    logic [31:0] exp_held = '0;

    typedef struct { logic [31:0] d; logic c; logic z; int req_edge; int lo; int hi; } exp_t;
    typedef struct { int st; logic [31:0] v; int sz; } msg_t;
    exp_t q0[$];
    exp_t q1[$];
    msg_t msgq[$];

    xpdr_mailbox #(.N_RD(2)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_data(wr_data), .wr_busy(wr_busy),
        .rd_req(rd_req), .rd_mode(rd_mode), .rd_done(rd_done), .rd_data(rd_data),
        .rd_c(rd_c), .rd_z(rd_z), .bc_sop(bc_sop), .bc_nib(bc_nib)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int szof(input logic [31:0] v);
        if (v[31:16] != 0) return 2;
        if (v[15:8] != 0) return 1;
        return 0;
    endfunction

    function automatic int nibs(input int s);
        return (s >= 2) ? 8 : (s == 1 ? 4 : 2);
    endfunction

    // Bench model of one read of the held value
    function automatic exp_t model(input logic [31:0] v, input int m);
        exp_t e;
        int mn, sn, n;
        logic [31:0] mask;
        mn = nibs(m);
        sn = nibs(szof(v));
        n = (mn < sn) ? mn : sn;
        mask = (n == 8) ? 32'hFFFF_FFFF : ((32'h1 << (4*n)) - 1);
        e.d = v & mask;
        e.c = e.d[4*mn-1];
        e.z = (e.d == 0);
        e.lo = 1 + n;
        e.hi = 2 + sn + n;
        e.req_edge = 0;
        return e;
    endfunction

    // Broadcast link decoder: records each message with its start cycle (R3)
    int dphase = 0;
    int dk = 0;
    int dsz = 0;
    int dst = -1;
    logic [31:0] dv = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (bc_sop) begin
                if (dst >= 0)
                    chk((cyc - dst) == 2 + nibs(dsz), "R3 message spacing", cyc - dst, 2 + nibs(dsz));
                dst = cyc;
                dsz = int'(bc_nib);
                dv = '0;
                dk = 0;
                dphase = 1;
            end else if (dphase == 1) begin
                chk(int'(bc_nib) == dsz, "R3 second header nibble", bc_nib, dsz);
                dphase = 2;
            end else if (dphase == 2) begin
                dv[4*dk +: 4] = bc_nib;
                dk++;
                if (dk == nibs(dsz)) begin
                    msg_t m;
                    m.st = dst; m.v = dv; m.sz = dsz;
                    msgq.push_back(m);
                    dphase = 0;
                end
            end
        end
    end

    // Monitor: pops expected items as readers complete (R5 R6 R7 R8)
    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < 2; i++) begin
                if (rd_done[i]) begin
                    exp_t e;
                    int dl;
                    if ((i == 0 && q0.size() == 0) || (i == 1 && q1.size() == 0)) begin
                        chk(1'b0, "R8 unexpected done", i, 0);
                    end else begin
                        e = (i == 0) ? q0.pop_front() : q1.pop_front();
                        dl = cyc - e.req_edge;
                        chk(rd_data[32*i +: 32] == e.d, "R5 read data", rd_data[32*i +: 32], e.d);
                        chk(rd_c[i] == e.c, "R6 carry flag", rd_c[i], e.c);
                        chk(rd_z[i] == e.z, "R7 zero flag", rd_z[i], e.z);
                        chk(dl >= e.lo && dl <= e.hi, "R8 latency", dl, e.hi);
                    end
                end
            end
        end
    end

    // Driver: issue reads on selected readers in the same cycle (R9)
    task automatic rd_pair(input int m0, input int m1);
        exp_t e;
        @(negedge clk);
        if (m0 >= 0) begin
            rd_req[0] = 1'b1; rd_mode[1:0] = 2'(m0);
            e = model(exp_held, m0); e.req_edge = cyc + 1; q0.push_back(e);
        end
        if (m1 >= 0) begin
            rd_req[1] = 1'b1; rd_mode[3:2] = 2'(m1);
            e = model(exp_held, m1); e.req_edge = cyc + 1; q1.push_back(e);
        end
        @(negedge clk);
        rd_req = '0;
        for (int k = 0; k < 40 && (q0.size() != 0 || q1.size() != 0); k++) @(negedge clk);
        chk(q0.size() == 0 && q1.size() == 0, "R9 reads completed", q0.size() + q1.size(), 0);
    endtask

    // Driver: write, measure busy length, wait until the value is broadcast (R1)
    task automatic wr_settle(input logic [31:0] v);
        int n;
        @(negedge clk);
        wr_req = 1'b1; wr_data = v;
        @(negedge clk);
        wr_req = 1'b0;
        n = 0;
        while (wr_busy && n < 20) begin n++; @(negedge clk); end
        chk(n == 2 + nibs(szof(v)), "R1 busy length", n, 2 + nibs(szof(v)));
        repeat (24) @(negedge clk);
        exp_held = v;
    endtask

    function automatic bit find_msg(input int st, output logic [31:0] v);
        foreach (msgq[i]) if (msgq[i].st == st) begin v = msgq[i].v; return 1'b1; end
        v = '0;
        return 1'b0;
    endfunction

    // Align a write's completion to a message boundary, or one cycle before (R4)
    task automatic boundary(input logic [31:0] oldv, input logic [31:0] newv, input int early);
        int b0, j;
        logic [31:0] got;
        bit f;
        wr_settle(oldv);
        @(negedge clk);
        while (!bc_sop) @(negedge clk);
        b0 = cyc;
        j = 10 - (2 + nibs(szof(newv))) - early;
        repeat (j - 1) @(negedge clk);
        wr_req = 1'b1; wr_data = newv;
        @(negedge clk);
        wr_req = 1'b0;
        repeat (40) @(negedge clk);
        f = find_msg(b0 + 10, got);
        if (early != 0) begin
            chk(f && got == newv, "R4 early completion shown at once", got, newv);
        end else begin
            chk(f && got == oldv, "R4 coincident completion deferred", got, oldv);
            f = find_msg(b0 + 20, got);
            chk(f && got == newv, "R4 value after deferral", got, newv);
        end
        exp_held = newv;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(wr_busy == 1'b0 && rd_done == 2'b00, "R3 reset idle outputs", {wr_busy, rd_done}, 0);
        chk(bc_sop == 1'b1 && bc_nib == 4'h0, "R3 reset header byte", {bc_sop, bc_nib}, 5'h10);
        rst_n = 1'b1;
        repeat (12) @(negedge clk);
        chk(msgq.size() > 0 && msgq[0].v == 0 && msgq[0].sz == 0, "R3 reset value zero byte",
            msgq.size() > 0 ? msgq[0].v : 32'hX, 0);
        rd_pair(2, 0);

        // Sizes at the thresholds (R1) with reads in all modes (R5 R6 R7 R9)
        wr_settle(32'h0000_00FF); rd_pair(0, 1);
        wr_settle(32'h0000_0100); rd_pair(0, 2);
        wr_settle(32'h0000_8000); rd_pair(0, 1);
        wr_settle(32'h0001_0000); rd_pair(1, 3);
        wr_settle(32'h8000_0001); rd_pair(2, 1);
        wr_settle(32'hDEAD_BEEF); rd_pair(0, 3);
        wr_settle(32'h0000_0080); rd_pair(0, 2);
        wr_settle(32'h0000_0000); rd_pair(1, 2);

        // R2: request during busy is ignored
        @(negedge clk);
        wr_req = 1'b1; wr_data = 32'h1122_3344;
        @(negedge clk);
        wr_data = 32'h0000_0055;
        @(negedge clk);
        wr_req = 1'b0;
        repeat (40) @(negedge clk);
        chk(msgq[$].v == 32'h1122_3344, "R2 ignored write absent from link", msgq[$].v, 32'h1122_3344);
        exp_held = 32'h1122_3344;
        rd_pair(3, -1);

        // R4 boundary cases
        boundary(32'hCAFE_F00D, 32'h0000_003C, 0);
        rd_pair(0, 2);
        boundary(32'h0BAD_F00D, 32'h0000_007E, 1);
        rd_pair(2, -1);
        boundary(32'h1234_5678, 32'h0000_9ABC, 0);
        rd_pair(1, 0);

        // Back-to-back reads on one reader landing at various offsets (R8)
        for (int k = 0; k < 6; k++) begin
            repeat (k) @(negedge clk);
            rd_pair(k % 3, -1);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule